// File: doc/BRIEF.md
# SDRAM Bank Command State Tracker

This block listens to the command strobes of a two-bank synchronous DRAM and keeps a state machine per bank. It tracks idle, row active, read burst, write burst, read burst with auto-precharge, and a short write-recovery phase. It decodes chip-select, RAS, CAS and WE (all active low) together with a bank-select address bit and an auto-precharge address bit. For every clock it reports the operation the command caused, and it flags commands that are not allowed in the addressed bank's current state.

A burst-length input sets how many cycles a read or write burst occupies, and a counter per bank retires the burst. The tracker is a passive observer meant to sit beside a memory controller or a bus monitor. It handles no data, checks no electrical timing, schedules no refresh and does not hold the mode-register contents. All outputs are registered and change on the clock edge that samples the command.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While `rstN` is low at a rising edge, every bank goes to idle (state code 0), `opCode` goes to 0 and `illegal` goes to 0.
- R2: Commands are encoded as {csN,rasN,casN,weN}: 1xxx deselect, 0111 NOP, 0110 burst stop, 0101 read, 0100 write, 0011 activate, 0010 precharge, 0001 refresh, 0000 mode set. `addr[11]` selects the bank and `addr[10]` is the auto-precharge / all-banks bit. The results of a command appear on the outputs the cycle after the edge that samples it. Operation codes: 0 none, 1 activate, 2 read, 3 read with auto-precharge, 4 write, 5 write with auto-precharge, 6 precharge, 7 burst stop, 8 refresh, 9 mode set. Bank i's state is `bankState[3i+2:3i]`, with codes 0 idle, 1 row active, 2 read burst, 3 write burst, 4 read burst with auto-precharge, 5 write recovery.
- R3: In an idle bank, activate moves the bank to row active. Read and write are illegal. Burst stop and precharge report operation 0 and change nothing.
- R4: In a row-active bank, read starts a read burst (state 4 if `addr[10]` is set, else state 2). Write starts a write burst (state 3). Precharge returns the bank to idle. Burst stop changes nothing, and activate is illegal.
- R5: `burstLen` codes 0,1,2,3 give bursts of 1,2,4,8 cycles. A burst state lasts exactly that many cycles unless a command to the same bank ends it.
- R6: During a read or write burst, burst stop returns the bank to row active. Read or write restarts a burst of the requested kind with a fresh count. Precharge moves the bank to idle.
- R7: A write burst that runs out enters write recovery for exactly 2 cycles. The bank then goes to row active, or to idle if the write carried `addr[10]`.
- R8: A read burst with auto-precharge goes to idle when it runs out. Every command addressed to that bank other than deselect and NOP is illegal.
- R9: In write recovery, read, write, activate and precharge to that bank are illegal. Burst stop reports operation 0.
- R10: Precharge with `addr[10]` set closes every bank that is row active or bursting. It is illegal if any bank is in read-with-auto-precharge or write recovery, and the lowest such bank is reported.
- R11: Refresh and mode set are accepted only when every bank is idle. Otherwise they are illegal, and the lowest non-idle bank is reported.
- R12: An illegal command raises `illegal` for the following cycle, reports the offending bank on `illegalBank`, reports operation 0, and applies no state change. A running burst keeps counting.
- R13: A command to one bank does not disturb another bank's burst count or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 12 | Address bus; bit 11 bank, bit 10 auto-precharge |
| burstLen | input | 2 | Burst length code (1,2,4,8) |
| bankState | output | 6 | Packed 3-bit state per bank |
| opCode | output | 4 | Operation caused by the last command |
| illegal | output | 1 | Last command was illegal |
| illegalBank | output | 1 | Bank that made the last command illegal |

## Verification
Two things can land on the same clock edge: a bank's burst counter expires, and a new command arrives either for that bank or for the other one. The bench places a read, write, burst stop or precharge exactly on the final cycle of a running burst. It also issues commands to one bank while the other bank's burst or recovery is retiring. A behavioural per-bank model in the bench predicts both outcomes, and every output is compared on every clock. The compare shows whether a command takes priority over expiry on its own bank while leaving the other bank's expiry intact.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACTIVE  = 3'd1,
    ST_READ    = 3'd2,
    ST_WRITE   = 3'd3,
    ST_READ_AP = 3'd4,
    ST_WREC    = 3'd5
  } bankStateE;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_ACTIVATE   = 4'd1,
    OP_READ       = 4'd2,
    OP_READ_AP    = 4'd3,
    OP_WRITE      = 4'd4,
    OP_WRITE_AP   = 4'd5,
    OP_PRECHARGE  = 4'd6,
    OP_BURST_STOP = 4'd7,
    OP_REFRESH    = 4'd8,
    OP_MODE_SET   = 4'd9
  } opE;

  typedef enum logic [3:0] {
    CMD_DESL, CMD_NOP, CMD_BST, CMD_READ, CMD_WRITE,
    CMD_ACT, CMD_PRE, CMD_REF, CMD_MRS
  } cmdE;

  // Strobes from control to one bank's datapath
  typedef struct packed {
    logic toActive;
    logic toIdle;
    logic startRead;
    logic startWrite;
    logic autoPre;
  } bankStrobeT;

  function automatic cmdE decodeCmd(input logic cs, input logic ras,
                                    input logic cas, input logic we);
    cmdE c;
    if (cs) c = CMD_DESL;
    else begin
      case ({ras, cas, we})
        3'b111:  c = CMD_NOP;
        3'b110:  c = CMD_BST;
        3'b101:  c = CMD_READ;
        3'b100:  c = CMD_WRITE;
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        default: c = CMD_MRS;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/trk_bank.sv
module trk_bank
  import sdram_trk_pkg::*;
#(
  parameter int MAX_BL     = 8,
  parameter int BL_SEL_W   = 2,
  parameter int REC_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BL_SEL_W-1:0] burstLen,
  input  bankStrobeT          strobe,
  output bankStateE           stateQ
);
  localparam int CNT_W = (MAX_BL > 1) ? $clog2(MAX_BL) : 1;
  localparam int REC_W = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;

  logic [CNT_W-1:0] cntQ;
  logic [REC_W-1:0] recQ;
  logic             apWriteQ;
  logic [CNT_W-1:0] blLast;

  assign blLast = CNT_W'((32'd1 << burstLen) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      recQ     <= '0;
      apWriteQ <= 1'b0;
    end else if (strobe.toIdle) begin
      stateQ   <= ST_IDLE;
      apWriteQ <= 1'b0;
    end else if (strobe.toActive) begin
      stateQ <= ST_ACTIVE;
    end else if (strobe.startRead) begin
      stateQ <= strobe.autoPre ? ST_READ_AP : ST_READ;
      cntQ   <= blLast;
    end else if (strobe.startWrite) begin
      stateQ   <= ST_WRITE;
      cntQ     <= blLast;
      apWriteQ <= strobe.autoPre;
    end else begin
      case (stateQ)
        ST_READ, ST_READ_AP, ST_WRITE: begin
          if (cntQ == '0) begin
            case (stateQ)
              ST_READ:    stateQ <= ST_ACTIVE;
              ST_READ_AP: stateQ <= ST_IDLE;
              default: begin
                stateQ <= ST_WREC;
                recQ   <= REC_W'(REC_CYCLES - 1);
              end
            endcase
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        ST_WREC: begin
          if (recQ == '0) begin
            stateQ   <= apWriteQ ? ST_IDLE : ST_ACTIVE;
            apWriteQ <= 1'b0;
          end else begin
            recQ <= recQ - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: control never steers a bank that is in read with auto-precharge
  p_rdap_untouched_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_READ_AP) |-> (strobe == '0));

  // R3: an idle bank can only stay idle or open a row
  p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |=> (stateQ inside {ST_IDLE, ST_ACTIVE}));

  // R7: recovery leaves only toward row active or idle
  p_wrec_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WREC) |=> (stateQ inside {ST_WREC, ST_ACTIVE, ST_IDLE}));

  // R5: a burst with count remaining and no strobe keeps its state
  p_burst_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ inside {ST_READ, ST_WRITE, ST_READ_AP}) && cntQ != '0 && strobe == '0)
      |=> (stateQ == $past(stateQ)));

endmodule

// File: rtl/trk_ctrl.sv
module trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  parameter int BANK_BIT  = 11,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  bankStateE         bankSt [NUM_BANKS],
  output bankStrobeT        strobeD [NUM_BANKS],
  output opE                opQ,
  output logic              illegalQ,
  output logic [BANK_W-1:0] illegalBankQ
);
  cmdE               cmd;
  logic [BANK_W-1:0] tgt;
  logic              ap;
  bankStateE         tgtSt;
  logic              anyBusy, anyBlock, anyOpen;
  logic [BANK_W-1:0] firstBusy, firstBlock;
  opE                opD;
  logic              illD;
  logic [BANK_W-1:0] illBankD;

  assign cmd   = decodeCmd(csN, rasN, casN, weN);
  assign tgt   = addr[BANK_BIT +: BANK_W];
  assign ap    = addr[AP_BIT];
  assign tgtSt = bankSt[tgt];

  // Lowest-index bank that is non-idle / blocks a precharge-all
  always_comb begin
    anyBusy    = 1'b0;
    anyBlock   = 1'b0;
    anyOpen    = 1'b0;
    firstBusy  = '0;
    firstBlock = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (bankSt[i] != ST_IDLE) begin
        anyBusy   = 1'b1;
        firstBusy = BANK_W'(i);
      end
      if (bankSt[i] inside {ST_READ_AP, ST_WREC}) begin
        anyBlock   = 1'b1;
        firstBlock = BANK_W'(i);
      end
      if (bankSt[i] inside {ST_ACTIVE, ST_READ, ST_WRITE}) anyOpen = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) strobeD[i] = '0;
    opD      = OP_NONE;
    illD     = 1'b0;
    illBankD = tgt;
    case (cmd)
      CMD_BST: begin
        if (tgtSt inside {ST_READ, ST_WRITE}) begin
          strobeD[tgt].toActive = 1'b1;
          opD = OP_BURST_STOP;
        end else if (tgtSt == ST_READ_AP) begin
          illD = 1'b1;
        end
      end
      CMD_READ, CMD_WRITE: begin
        if (tgtSt inside {ST_ACTIVE, ST_READ, ST_WRITE}) begin
          strobeD[tgt].autoPre = ap;
          if (cmd == CMD_READ) begin
            strobeD[tgt].startRead = 1'b1;
            opD = ap ? OP_READ_AP : OP_READ;
          end else begin
            strobeD[tgt].startWrite = 1'b1;
            opD = ap ? OP_WRITE_AP : OP_WRITE;
          end
        end else begin
          illD = 1'b1;
        end
      end
      CMD_ACT: begin
        if (tgtSt == ST_IDLE) begin
          strobeD[tgt].toActive = 1'b1;
          opD = OP_ACTIVATE;
        end else begin
          illD = 1'b1;
        end
      end
      CMD_PRE: begin
        if (ap) begin
          if (anyBlock) begin
            illD     = 1'b1;
            illBankD = firstBlock;
          end else begin
            for (int i = 0; i < NUM_BANKS; i++)
              if (bankSt[i] inside {ST_ACTIVE, ST_READ, ST_WRITE})
                strobeD[i].toIdle = 1'b1;
            if (anyOpen) opD = OP_PRECHARGE;
          end
        end else if (tgtSt inside {ST_ACTIVE, ST_READ, ST_WRITE}) begin
          strobeD[tgt].toIdle = 1'b1;
          opD = OP_PRECHARGE;
        end else if (tgtSt != ST_IDLE) begin
          illD = 1'b1;
        end
      end
      CMD_REF, CMD_MRS: begin
        if (anyBusy) begin
          illD     = 1'b1;
          illBankD = firstBusy;
        end else begin
          opD = (cmd == CMD_REF) ? OP_REFRESH : OP_MODE_SET;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ          <= OP_NONE;
      illegalQ     <= 1'b0;
      illegalBankQ <= '0;
    end else begin
      opQ          <= opD;
      illegalQ     <= illD;
      illegalBankQ <= illD ? illBankD : '0;
    end
  end

  logic allIdleNow;
  always_comb begin
    allIdleNow = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bankSt[i] != ST_IDLE) allIdleNow = 1'b0;
  end

  // R11: after an accepted refresh or mode set every bank is idle
  p_refresh_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opQ inside {OP_REFRESH, OP_MODE_SET}) |-> allIdleNow);

  // R12: a flagged command reports no operation
  p_illegal_no_op_r12: assert property (@(posedge clk) disable iff (!rstN)
    illegalQ |-> (opQ == OP_NONE));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 12,
  parameter int BANK_BIT   = 11,
  parameter int AP_BIT     = 10,
  parameter int MAX_BL     = 8,
  parameter int BL_SEL_W   = 2,
  parameter int REC_CYCLES = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BL_SEL_W-1:0]    burstLen,
  output logic [NUM_BANKS*3-1:0] bankState,
  output logic [3:0]             opCode,
  output logic                   illegal,
  output logic [BANK_W-1:0]      illegalBank
);
  bankStateE  bankSt  [NUM_BANKS];
  bankStrobeT strobes [NUM_BANKS];
  opE         opQ;

  trk_ctrl #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
    .BANK_BIT(BANK_BIT), .AP_BIT(AP_BIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .bankSt(bankSt), .strobeD(strobes),
    .opQ(opQ), .illegalQ(illegal), .illegalBankQ(illegalBank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    trk_bank #(
      .MAX_BL(MAX_BL), .BL_SEL_W(BL_SEL_W), .REC_CYCLES(REC_CYCLES)
    ) uBank (
      .clk(clk), .rstN(rstN), .burstLen(burstLen),
      .strobe(strobes[b]), .stateQ(bankSt[b])
    );
    assign bankState[3*b +: 3] = bankSt[b];
  end

  assign opCode = opQ;

endmodule

// File: tb/tb_sdram_bank_tracker.sv
`timescale 1ns/100ps
module tb_sdram_bank_tracker;
  logic        clk = 1'b0;
  logic        rstN;
  logic        csN, rasN, casN, weN;
  logic [11:0] addr;
  logic [1:0]  burstLen;
  logic [5:0]  bankState;
  logic [3:0]  opCode;
  logic        illegal;
  logic        illegalBank;

  int checks = 0;
  int failures = 0;

  localparam logic [3:0] C_DESL = 4'b1111, C_NOP = 4'b0111, C_BST = 4'b0110,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_ACT = 4'b0011,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  sdram_bank_tracker dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .burstLen(burstLen), .bankState(bankState),
    .opCode(opCode), .illegal(illegal), .illegalBank(illegalBank)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  int mSt[2], mCnt[2], mRec[2], mApw[2];
  int eOp, eIll, eBank;

  function automatic logic [11:0] ad(input int bank, input int ap);
    return {bank[0], ap[0], 10'h0};
  endfunction

  task automatic modelStep(input logic [3:0] c, input logic [11:0] a,
                           input logic rst, input int bl);
    int sk[2];
    int t, ap, len, lowBusy, lowBlk, anyOpen;
    if (rst) begin
      for (int b = 0; b < 2; b++) begin mSt[b] = 0; mCnt[b] = 0; mRec[b] = 0; mApw[b] = 0; end
      eOp = 0; eIll = 0; eBank = 0;
      return;
    end
    t = a[11]; ap = a[10]; len = 1 << bl;
    sk[0] = 0; sk[1] = 0; eOp = 0; eIll = 0; eBank = t;
    lowBusy = -1; lowBlk = -1; anyOpen = 0;
    for (int b = 1; b >= 0; b--) begin
      if (mSt[b] != 0) lowBusy = b;
      if (mSt[b] == 4 || mSt[b] == 5) lowBlk = b;
      if (mSt[b] >= 1 && mSt[b] <= 3) anyOpen = 1;
    end
    if (c[3]) ;
    else case (c)
      C_NOP: ;
      C_BST: if (mSt[t] == 2 || mSt[t] == 3) begin sk[t] = 1; eOp = 7; end
             else if (mSt[t] == 4) eIll = 1;
      C_RD, C_WR:
        if (mSt[t] >= 1 && mSt[t] <= 3) begin
          sk[t] = (c == C_RD) ? 3 : 4;
          eOp = (c == C_RD) ? (ap ? 3 : 2) : (ap ? 5 : 4);
        end else eIll = 1;
      C_ACT: if (mSt[t] == 0) begin sk[t] = 1; eOp = 1; end else eIll = 1;
      C_PRE:
        if (ap) begin
          if (lowBlk >= 0) begin eIll = 1; eBank = lowBlk; end
          else begin
            for (int b = 0; b < 2; b++) if (mSt[b] >= 1 && mSt[b] <= 3) sk[b] = 2;
            if (anyOpen) eOp = 6;
          end
        end else if (mSt[t] >= 1 && mSt[t] <= 3) begin sk[t] = 2; eOp = 6; end
        else if (mSt[t] != 0) eIll = 1;
      default:
        if (lowBusy >= 0) begin eIll = 1; eBank = lowBusy; end
        else eOp = (c == C_REF) ? 8 : 9;
    endcase
    if (!eIll) eBank = 0;
    for (int b = 0; b < 2; b++) begin
      case (sk[b])
        1: mSt[b] = 1;
        2: begin mSt[b] = 0; mApw[b] = 0; end
        3: begin mSt[b] = ap ? 4 : 2; mCnt[b] = len - 1; end
        4: begin mSt[b] = 3; mCnt[b] = len - 1; mApw[b] = ap; end
        default:
          if (mSt[b] == 2 || mSt[b] == 3 || mSt[b] == 4) begin
            if (mCnt[b] == 0) begin
              if (mSt[b] == 2) mSt[b] = 1;
              else if (mSt[b] == 4) mSt[b] = 0;
              else begin mSt[b] = 5; mRec[b] = 1; end
            end else mCnt[b]--;
          end else if (mSt[b] == 5) begin
            if (mRec[b] == 0) begin mSt[b] = mApw[b] ? 0 : 1; mApw[b] = 0; end
            else mRec[b]--;
          end
      endcase
    end
  endtask

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Drive one command, advance one edge, compare everything
  task automatic step(input logic [3:0] c, input logic [11:0] a, input string tag);
    {csN, rasN, casN, weN} = c;
    addr = a;
    @(posedge clk);
    modelStep(c, a, !rstN, int'(burstLen));
    #1;
    chk(tag, "bankState", int'(bankState), (mSt[1] << 3) | mSt[0]);
    chk(tag, "opCode", int'(opCode), eOp);
    chk(tag, "illegal", int'(illegal), eIll);
    chk(tag, "illegalBank", int'(illegalBank), eBank);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(C_NOP, 12'h0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; burstLen = 2'd2;
    {csN, rasN, casN, weN} = C_DESL; addr = '0;
    step(C_ACT, ad(0, 0), "R1");
    step(C_NOP, ad(0, 0), "R1");
    #1 rstN = 1'b1;
    step(C_DESL, ad(1, 1), "R2");
    // idle bank
    step(C_RD, ad(0, 0), "R3");
    step(C_WR, ad(1, 0), "R3");
    step(C_BST, ad(0, 0), "R3");
    step(C_PRE, ad(0, 0), "R3");
    step(C_ACT, ad(0, 0), "R3");
    step(C_ACT, ad(0, 0), "R12");
    step(C_BST, ad(0, 0), "R4");
    // read of 4 runs out
    step(C_RD, ad(0, 0), "R4");
    idle(5, "R5");
    // write of 4 then two recovery cycles
    step(C_WR, ad(0, 0), "R7");
    idle(4, "R7");
    step(C_RD, ad(0, 0), "R9");
    step(C_BST, ad(0, 0), "R9");
    idle(2, "R7");
    // read interrupts
    step(C_RD, ad(0, 0), "R6");
    step(C_NOP, 12'h0, "R6");
    step(C_RD, ad(0, 0), "R6");
    step(C_WR, ad(0, 0), "R6");
    step(C_BST, ad(0, 0), "R6");
    step(C_WR, ad(0, 0), "R6");
    step(C_PRE, ad(0, 0), "R6");
    // read with auto-precharge rejects everything
    step(C_ACT, ad(0, 0), "R4");
    step(C_RD, ad(0, 1), "R8");
    step(C_BST, ad(0, 0), "R8");
    step(C_PRE, ad(0, 0), "R8");
    step(C_RD, ad(0, 0), "R8");
    idle(3, "R8");
    // burst expiry collides with a command on the other bank
    step(C_ACT, ad(0, 0), "R13");
    step(C_ACT, ad(1, 0), "R13");
    step(C_RD, ad(0, 0), "R13");
    idle(2, "R13");
    step(C_WR, ad(1, 1), "R13");
    step(C_RD, ad(0, 1), "R13");
    step(C_PRE, ad(0, 1), "R10");
    step(C_REF, 12'h0, "R11");
    idle(4, "R13");
    // expiry and same-bank command in the last burst cycle
    step(C_RD, ad(1, 0), "R9");
    step(C_ACT, ad(1, 0), "R9");
    idle(1, "R7");
    step(C_ACT, ad(1, 0), "R7");
    step(C_WR, ad(1, 0), "R7");
    idle(3, "R7");
    step(C_RD, ad(1, 0), "R6");
    step(C_PRE, ad(1, 1), "R10");
    step(C_MRS, 12'h0, "R11");
    step(C_PRE, ad(0, 1), "R10");
    step(C_REF, 12'h0, "R11");
    step(C_MRS, 12'h0, "R11");
    // burst lengths 1 and 8
    burstLen = 2'd0;
    step(C_ACT, ad(1, 0), "R5");
    step(C_RD, ad(1, 0), "R5");
    idle(2, "R5");
    burstLen = 2'd3;
    step(C_WR, ad(1, 1), "R5");
    idle(11, "R7");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] cset [9];
      cset = '{C_DESL, C_NOP, C_BST, C_RD, C_WR, C_ACT, C_PRE, C_REF, C_MRS};
      burstLen = 2'($urandom_range(0, 3));
      step(cset[$urandom_range(0, 8)], ad($urandom_range(0, 1), $urandom_range(0, 1)), "R13");
      if ($urandom_range(0, 2) == 0) step(C_NOP, 12'h0, "R5");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule